// File: doc/BRIEF.md
# PS/2 Host Receive Engine

This block is the host-side receiver for a PS/2 device link. It watches the open-drain clock and data lines, passes them through two-flop synchronizers and a short glitch filter, and steps a frame tracker on each filtered falling edge of the device clock. Each frame has eleven positions: a start bit, eight data bits sent least significant first, an odd parity bit and a stop bit. When all three framing checks pass, the byte goes into a shallow receive queue. A consumer reads the head of the queue and pops it with a single-cycle strobe.

If a frame fails, the engine records the position where the failure happened as a small error code. It also pulls the device clock low, and keeps it low until the consumer clears the code, so the device cannot send more. A frame that stalls between clock edges for longer than a programmable timeout is dropped without raising an error. A byte of zero is never queued. When the queue is empty, the read port shows zero.

Top module: `ps2_host_rx`

## Requirements
- R1: Bits are taken only on a falling edge of the filtered device clock. A change on the data line while the clock is low, or at the rising edge, does not affect the received byte.
- R2: The start bit must read 0. If it reads 1, the error code becomes 1.
- R3: The eight data bits arrive least significant bit first. The queued byte equals the value sent.
- R4: Parity is odd. The parity bit must be 1 when the data holds an even number of ones, and 0 otherwise. A mismatch gives error code 10 and nothing is queued.
- R5: The stop bit must read 1. If it reads 0, the error code becomes 11 and nothing is queued.
- R6: While the error code is non-zero, `kb_clk_pull_o` is 1, falling edges are ignored, and the code holds its value. A one-cycle `err_clr_i` pulse returns the code to 0 and releases the clock.
- R7: The queue has 8 slots with one always left unused, so it holds 7 bytes. A byte that arrives when the queue is full is dropped. Bytes come out in arrival order.
- R8: A received byte of 0x00 is never queued. While the queue is empty, `rx_byte_o` reads 0 and `rx_empty_o` is 1.
- R9: After each completed or aborted frame, the shift register clears to 0 and the parity accumulator resets to 1. Frames sent back to back are therefore received independently.
- R10: If the gap between falling edges inside a frame exceeds CYC_PER_US*TIMEOUT_US cycles (200 by default), the partial frame is discarded with no error code. The next full frame is then received correctly.
- R11: A clock-line pulse shorter than FILT_CYC cycles (4 by default) is not seen as an edge.
- R12: After reset, the queue is empty, the error code is 0 and the clock is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| kb_clk_i | input | 1 | Sensed level of the device clock line |
| kb_dat_i | input | 1 | Sensed level of the device data line |
| kb_clk_pull_o | output | 1 | 1 = pull the device clock line low (inhibit) |
| rx_byte_o | output | 8 | Byte at the head of the receive queue, 0 when empty |
| rx_empty_o | output | 1 | Receive queue empty |
| rx_pop_i | input | 1 | Pop strobe for the queue head |
| err_code_o | output | 4 | Frame position of the last failure, 0 when none |
| err_clr_i | input | 1 | Clears the latched error code |

## Verification
The assertions check four things on every cycle. The frame state moves only on a filtered falling edge or a timeout. The clock is pulled low whenever an error is latched. That error stays unchanged until it is cleared. An empty queue reads zero and stays empty until the frame tracker pushes a byte. The bench scenarios cover behaviour that depends on a whole frame:
- bit order and parity across different byte values
- the exact error code for each bad position
- dropping of zero bytes
- the seven-byte capacity and overflow
- recovery after a timeout
- rejection of short clock glitches

// File: rtl/ps2_host_rx_pkg.sv
package ps2_host_rx_pkg;

    localparam int ERR_W = 4;

    // Frame position numbering; the error code reports this value.
    typedef enum logic [3:0] {
        FS_IDLE  = 4'd0,
        FS_START = 4'd1,
        FS_D0    = 4'd2,
        FS_D1    = 4'd3,
        FS_D2    = 4'd4,
        FS_D3    = 4'd5,
        FS_D4    = 4'd6,
        FS_D5    = 4'd7,
        FS_D6    = 4'd8,
        FS_D7    = 4'd9,
        FS_PAR   = 4'd10,
        FS_STOP  = 4'd11
    } frame_st_e;

endpackage

// File: rtl/ps2_rx_sync.sv
module ps2_rx_sync #(
    parameter int FILT_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic level_o
);
    localparam int CW = (FILT_CYC > 1) ? $clog2(FILT_CYC) : 1;

    typedef struct packed {
        logic [1:0]    sync;
        logic          filt;
        logic [CW-1:0] cnt;
    } sy_t;

    sy_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.sync = {s_q.sync[0], raw_i};
        if (s_q.sync[1] == s_q.filt) begin
            s_d.cnt = '0;
        end else if (s_q.cnt == CW'(FILT_CYC - 1)) begin
            s_d.filt = s_q.sync[1];
            s_d.cnt  = '0;
        end else begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{sync: 2'b11, filt: 1'b1, cnt: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign level_o = s_q.filt;
endmodule

// File: rtl/ps2_rx_frame.sv
module ps2_rx_frame
    import ps2_host_rx_pkg::*;
#(
    parameter int TMO_CYC = 200
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clk_lvl_i,
    input  logic             dat_lvl_i,
    input  logic             err_clr_i,
    output logic             push_o,
    output logic [7:0]       push_byte_o,
    output logic [ERR_W-1:0] err_o,
    output logic             tmo_o,
    output frame_st_e        state_o
);
    localparam int TW = $clog2(TMO_CYC + 1);

    typedef struct packed {
        frame_st_e        st;
        logic [7:0]       sh;
        logic             par;
        logic [ERR_W-1:0] err;
        logic             push;
        logic [7:0]       pbyte;
        logic             prev;
        logic [TW-1:0]    cnt;
    } fr_t;

    fr_t       f_d, f_q;
    frame_st_e nxt;
    logic      fall;
    logic      tmo_c;

    always_comb begin
        f_d      = f_q;
        f_d.push = 1'b0;
        f_d.prev = clk_lvl_i;
        tmo_c    = 1'b0;
        fall     = f_q.prev & ~clk_lvl_i;
        nxt      = frame_st_e'(f_q.st + 4'd1);

        if (err_clr_i) begin
            f_d.err = '0;
        end

        if (f_q.err != '0) begin
            // inhibited: edges ignored
        end else if (fall) begin
            f_d.st  = nxt;
            f_d.cnt = '0;
            case (nxt)
                FS_START: begin
                    if (dat_lvl_i) begin
                        f_d.err = ERR_W'(nxt);
                        f_d.st  = FS_IDLE;
                        f_d.sh  = '0;
                        f_d.par = 1'b1;
                    end
                end
                FS_D0, FS_D1, FS_D2, FS_D3,
                FS_D4, FS_D5, FS_D6, FS_D7: begin
                    f_d.sh = {dat_lvl_i, f_q.sh[7:1]};
                    if (dat_lvl_i) begin
                        f_d.par = ~f_q.par;
                    end
                end
                FS_PAR: begin
                    if (dat_lvl_i != f_q.par) begin
                        f_d.err = ERR_W'(nxt);
                        f_d.st  = FS_IDLE;
                        f_d.sh  = '0;
                        f_d.par = 1'b1;
                    end
                end
                FS_STOP: begin
                    if (!dat_lvl_i) begin
                        f_d.err = ERR_W'(nxt);
                    end else begin
                        f_d.push  = 1'b1;
                        f_d.pbyte = f_q.sh;
                    end
                    f_d.st  = FS_IDLE;
                    f_d.sh  = '0;
                    f_d.par = 1'b1;
                end
                default: begin
                    f_d.err = ERR_W'(nxt);
                    f_d.st  = FS_IDLE;
                    f_d.sh  = '0;
                    f_d.par = 1'b1;
                end
            endcase
        end else if (f_q.st != FS_IDLE) begin
            if (f_q.cnt == TW'(TMO_CYC)) begin
                tmo_c   = 1'b1;
                f_d.st  = FS_IDLE;
                f_d.sh  = '0;
                f_d.par = 1'b1;
                f_d.cnt = '0;
            end else begin
                f_d.cnt = f_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            f_q <= '{st: FS_IDLE, sh: '0, par: 1'b1, err: '0, push: 1'b0,
                     pbyte: '0, prev: 1'b1, cnt: '0};
        end else begin
            f_q <= f_d;
        end
    end

    assign push_o      = f_q.push;
    assign push_byte_o = f_q.pbyte;
    assign err_o       = f_q.err;
    assign tmo_o       = tmo_c;
    assign state_o     = f_q.st;
endmodule

// File: rtl/ps2_rx_queue.sv
module ps2_rx_queue #(
    parameter int DEPTH = 8,
    parameter int DW    = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_i,
    input  logic [DW-1:0] push_data_i,
    input  logic          pop_i,
    output logic [DW-1:0] head_o,
    output logic          empty_o
);
    localparam int PW = $clog2(DEPTH);

    typedef struct packed {
        logic [PW-1:0] wp;
        logic [PW-1:0] rp;
    } qp_t;

    qp_t           p_d, p_q;
    logic [DW-1:0] mem_q [DEPTH];
    logic          full, empty, wr, rd;

    always_comb begin
        empty = (p_q.wp == p_q.rp);
        full  = (PW'(p_q.wp + 1'b1) == p_q.rp);
        wr    = push_i && (push_data_i != '0) && !full;
        rd    = pop_i && !empty;
        p_d   = p_q;
        if (wr) p_d.wp = p_q.wp + 1'b1;
        if (rd) p_d.rp = p_q.rp + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p_q <= '0;
        end else begin
            p_q <= p_d;
        end
    end

    always_ff @(posedge clk) begin
        if (wr) mem_q[p_q.wp] <= push_data_i;
    end

    assign head_o  = empty ? '0 : mem_q[p_q.rp];
    assign empty_o = empty;
endmodule

// File: rtl/ps2_host_rx.sv
module ps2_host_rx
    import ps2_host_rx_pkg::*;
#(
    parameter int CYC_PER_US = 2,
    parameter int TIMEOUT_US = 100,
    parameter int FILT_CYC   = 4,
    parameter int Q_DEPTH    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             kb_clk_i,
    input  logic             kb_dat_i,
    output logic             kb_clk_pull_o,
    output logic [7:0]       rx_byte_o,
    output logic             rx_empty_o,
    input  logic             rx_pop_i,
    output logic [ERR_W-1:0] err_code_o,
    input  logic             err_clr_i
);
    localparam int TMO_CYC = CYC_PER_US * TIMEOUT_US;
    localparam int NLINE   = 2;

    logic [NLINE-1:0] raw_lines, lvl_lines;
    logic             fr_push, fr_tmo;
    logic [7:0]       fr_byte;
    logic [ERR_W-1:0] fr_err;
    frame_st_e        fr_state;

    assign raw_lines = {kb_dat_i, kb_clk_i};

    for (genvar g = 0; g < NLINE; g++) begin : g_line
        ps2_rx_sync #(.FILT_CYC(FILT_CYC)) u_sync (
            .clk     (clk),
            .rst_n   (rst_n),
            .raw_i   (raw_lines[g]),
            .level_o (lvl_lines[g])
        );
    end

    ps2_rx_frame #(.TMO_CYC(TMO_CYC)) u_frame (
        .clk         (clk),
        .rst_n       (rst_n),
        .clk_lvl_i   (lvl_lines[0]),
        .dat_lvl_i   (lvl_lines[1]),
        .err_clr_i   (err_clr_i),
        .push_o      (fr_push),
        .push_byte_o (fr_byte),
        .err_o       (fr_err),
        .tmo_o       (fr_tmo),
        .state_o     (fr_state)
    );

    ps2_rx_queue #(.DEPTH(Q_DEPTH), .DW(8)) u_queue (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_i      (fr_push),
        .push_data_i (fr_byte),
        .pop_i       (rx_pop_i),
        .head_o      (rx_byte_o),
        .empty_o     (rx_empty_o)
    );

    assign kb_clk_pull_o = (fr_err != '0);
    assign err_code_o    = fr_err;
endmodule

// File: rtl/ps2_host_rx_chk.sv
module ps2_host_rx_chk
    import ps2_host_rx_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             clk_lvl,
    input logic             tmo,
    input logic             push,
    input frame_st_e        state,
    input logic [ERR_W-1:0] err,
    input logic             err_clr,
    input logic             pull,
    input logic             empty,
    input logic [7:0]       head
);
    logic prev_lvl;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_lvl <= 1'b1;
        else        prev_lvl <= clk_lvl;
    end

    p_state_on_fall_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!(prev_lvl && !clk_lvl) && !tmo) |=> $stable(state));

    p_pull_when_err_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (err != '0) |-> pull);

    p_err_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((err != '0) && !err_clr) |=> $stable(err));

    p_empty_reads_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> (head == 8'h00));

    p_empty_until_push_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && !push) |=> empty);
endmodule

bind ps2_host_rx ps2_host_rx_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .clk_lvl (lvl_lines[0]),
    .tmo     (fr_tmo),
    .push    (fr_push),
    .state   (fr_state),
    .err     (fr_err),
    .err_clr (err_clr_i),
    .pull    (kb_clk_pull_o),
    .empty   (rx_empty_o),
    .head    (rx_byte_o)
);

// File: tb/ps2_host_rx_tb.sv
module ps2_host_rx_tb;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 40;
    localparam int NVEC       = 9;
    // {data[15:8], flip_parity[7], bad_start[6], bad_stop[5], rsv[4], exp_err[3:0]}
    localparam logic [15:0] VEC [NVEC] = '{
        16'hA500, 16'h0100, 16'h8000, 16'hFF00, 16'h3C00,
        16'h558A, 16'h7741, 16'h992B, 16'h0000
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       dev_clk = 1'b1, dev_dat = 1'b1;
    logic       rx_pop = 1'b0, err_clr = 1'b0;
    logic       pull, empty;
    logic [7:0] head;
    logic [3:0] err;
    int         n_chk = 0, n_bad = 0;
    bit         done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ps2_host_rx u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .kb_clk_i      (dev_clk & ~pull),
        .kb_dat_i      (dev_dat),
        .kb_clk_pull_o (pull),
        .rx_byte_o     (head),
        .rx_empty_o    (empty),
        .rx_pop_i      (rx_pop),
        .err_code_o    (err),
        .err_clr_i     (err_clr)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bit(input logic b, input bit scramble);
        dev_dat = b;
        wait_cyc(HALF);
        dev_clk = 1'b0;
        wait_cyc(HALF/2);
        if (scramble) dev_dat = ~b;
        wait_cyc(HALF - HALF/2);
        dev_clk = 1'b1;
    endtask

    task automatic send_frame(input logic [7:0] d, input bit flip, input bit bstart,
                              input bit bstop, input bit scramble);
        logic par;
        par = ~(^d) ^ flip;
        send_bit(bstart, scramble);
        for (int i = 0; i < 8; i++) send_bit(d[i], scramble);
        send_bit(par, scramble);
        send_bit(~bstop, scramble);
        dev_dat = 1'b1;
        wait_cyc(20);
    endtask

    task automatic pop_one;
        rx_pop = 1'b1;
        wait_cyc(1);
        rx_pop = 1'b0;
        wait_cyc(1);
    endtask

    task automatic clear_err;
        err_clr = 1'b1;
        wait_cyc(1);
        err_clr = 1'b0;
        wait_cyc(10);
    endtask

    initial begin
        wait_cyc(5);
        rst_n = 1'b1;
        wait_cyc(5);
        // R12 reset state
        chk("R12 empty", empty, 1);
        chk("R12 head", head, 0);
        chk("R12 err", err, 0);
        chk("R12 pull", pull, 0);

        // Table of frames (R2 R3 R4 R5 R8 R9 back to back)
        for (int v = 0; v < NVEC; v++) begin
            logic [7:0] d;
            logic [3:0] e;
            d = VEC[v][15:8];
            e = VEC[v][3:0];
            send_frame(d, VEC[v][7], VEC[v][6], VEC[v][5], 1'b0);
            if (e != 0) begin
                chk(e == 4'd1 ? "R2 start err" : (e == 4'd10 ? "R4 parity err" : "R5 stop err"),
                    err, e);
                chk("R6 pull on err", pull, 1);
                chk("R5 no queue on err", empty, 1);
                wait_cyc(100);
                chk("R6 err held", err, e);
                clear_err();
                chk("R6 cleared", err, 0);
                chk("R6 released", pull, 0);
            end else if (d == 8'h00) begin
                chk("R8 zero dropped", empty, 1);
                chk("R8 empty head", head, 0);
            end else begin
                chk("R3 R9 byte", head, d);
                chk("R4 good parity no err", err, 0);
                pop_one();
                chk("R8 empty after pop", empty, 1);
            end
        end

        // R1: data changes while clock low must not matter
        send_frame(8'hC6, 1'b0, 1'b0, 1'b0, 1'b1);
        chk("R1 falling-edge sample", head, 8'hC6);
        chk("R1 no err", err, 0);
        pop_one();

        // R7: overflow, capacity seven
        for (int k = 1; k <= 9; k++) send_frame(8'(k), 1'b0, 1'b0, 1'b0, 1'b0);
        for (int k = 1; k <= 7; k++) begin
            chk("R7 fifo order", head, k);
            pop_one();
        end
        chk("R7 overflow dropped", empty, 1);

        // R10: partial frame then timeout
        send_bit(1'b0, 1'b0);
        send_bit(1'b1, 1'b0);
        send_bit(1'b0, 1'b0);
        dev_dat = 1'b1;
        wait_cyc(400);
        chk("R10 no err on timeout", err, 0);
        chk("R10 nothing queued", empty, 1);
        send_frame(8'h6B, 1'b0, 1'b0, 1'b0, 1'b0);
        chk("R10 recovered byte", head, 8'h6B);
        pop_one();

        // R11: short glitch on clock while data high
        dev_clk = 1'b0;
        wait_cyc(2);
        dev_clk = 1'b1;
        wait_cyc(30);
        chk("R11 glitch ignored", err, 0);
        send_frame(8'h5A, 1'b0, 1'b0, 1'b0, 1'b0);
        chk("R11 next frame", head, 8'h5A);
        pop_one();

        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule